// File: doc/BRIEF.md
# PHY DLL Reconfiguration Sequencer

This block sequences the delay-locked loop of a storage-card PHY whenever a new card clock frequency is requested. A single request strobe carries a frequency band code, a 4-bit output tap delay, a 4-bit charge-pump trim and a 3-bit drive-strength code. The sequencer issues masked writes to the PHY control registers through a simple write port. It reads the PHY status register through a read port that returns data one cycle after the read strobe. It also raises a one-cycle clock-update pulse toward the card clock divider.

If the DLL is running when a request arrives, the sequencer first switches it off. It then requests the clock change. At identification speed it stops at that point. At any faster band it programs the tap delay, the band select, and the trim and drive strength. It then enables the DLL and polls its ready bit at a fixed interval until the bit is seen or a cycle budget runs out. The poll interval and the timeout are counted in clock cycles from parameters.

Top module: `phy_dll_sequencer`

## Requirements
- R1: If the DLL-on flag is set when a request is accepted, the first PHY write goes to address 0x100, has mask bit 1 set and data bit 1 clear, and the DLL-on flag drops; this write comes before the clock-update pulse.
- R2: Band code 0 (400 kHz or less) ends the request after the clock-update pulse, with no further PHY write and the DLL-on flag low.
- R3: For band codes 1 to 3, the first write after the clock update goes to address 0x10C and sets bit 20 and bits 15:12 to the tap value.
- R4: The next write goes to address 0x110 and sets bits 9:8. Band code 1 (200 MHz) gives 9:8 = 00, band code 2 (100 MHz) gives 10, and band code 3 (any other fast clock) gives 01.
- R5: One write to 0x100 then places the trim in bits 7:4 and the drive code in bits 22:20. A separate later write to 0x100 sets bit 1 (DLL enable).
- R6: A request whose drive code is above 4 (valid codes: 0=50, 1=33, 2=66, 3=100, 4=40 ohm) is ignored: busy stays low and no write is issued.
- R7: After the enable write, the sequencer reads address 0x130 and repeats the read every POLL_CYC idle cycles until bit 0 is seen set. It then sets the DLL-on flag and pulses done.
- R8: Every write carries a mask covering exactly its fields, so register bits outside those fields keep their values.
- R9: If the ready bit has not been seen once TIMEOUT_CYC cycles of polling have passed, the sticky timeout error rises together with done and the DLL-on flag. The next accepted request clears the error.
- R10: Busy is high from the cycle after an accepted request through the done cycle. A request that arrives while busy is ignored.
- R11: Each accepted request produces exactly one clock-update pulse. The pulse comes before any tap, band or trim write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Reconfiguration request strobe |
| band | input | 2 | Frequency band code: 0 slow, 1 200 MHz, 2 100 MHz, 3 other |
| tap_sel | input | 4 | Output tap delay select |
| cp_trim | input | 4 | DLL charge-pump trim |
| drv_code | input | 3 | Drive-strength code, 0 to 4 valid |
| wr_en | output | 1 | PHY register write strobe |
| wr_addr | output | 12 | PHY register byte address |
| wr_mask | output | 32 | Bits of the register changed by the write |
| wr_data | output | 32 | Write data, meaningful under the mask |
| rd_en | output | 1 | PHY register read strobe |
| rd_addr | output | 12 | PHY register read address |
| rd_data | input | 32 | Read data, valid the cycle after rd_en |
| clk_upd | output | 1 | One-cycle pulse asking the divider to change the clock |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| tmo_err | output | 1 | Sticky ready-timeout error |
| dll_on | output | 1 | DLL is considered running |

## Verification
The bench sweeps every band code against many tap, trim and drive values. It alternates between runs with the DLL already on and runs with it off. For each run it checks the logged write order and the final register contents, including preset background bits. A design that skipped the switch-off would leave the enable bit set during the clock change. A design with swapped band bits would program 100 MHz as the default band. An unmasked write would wipe the background pattern. Separate cases drive invalid drive codes, which must not start a sequence, and a second request during a run, which must not restart it or retarget the tap. A PHY model that never becomes ready checks that the error is raised at the timeout and cleared by the next request.

// File: rtl/phy_dll_pkg.sv
package phy_dll_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL1 = 12'h100;
    localparam logic [ADDR_W-1:0] A_CTRL4 = 12'h10C;
    localparam logic [ADDR_W-1:0] A_CTRL5 = 12'h110;
    localparam logic [ADDR_W-1:0] A_STAT1 = 12'h130;

    localparam int B_DLL_EN  = 1;
    localparam int B_TAP_EN  = 20;
    localparam int B_TAP_LO  = 12;
    localparam int B_BAND_LO = 8;
    localparam int B_TRIM_LO = 4;
    localparam int B_DRV_LO  = 20;
    localparam int B_RDY     = 0;

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    localparam logic [2:0] DRV_MAX = 3'd4;

    typedef enum logic [1:0] {
        BAND_SLOW = 2'd0,
        BAND_200M = 2'd1,
        BAND_100M = 2'd2,
        BAND_MID  = 2'd3
    } band_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DLL_OFF, ST_CLK, ST_TAP, ST_BAND,
        ST_TRIM, ST_ENA, ST_READ, ST_CHECK, ST_WAIT, ST_DONE
    } step_e;

    typedef struct packed {
        band_e      band;
        logic [3:0] tap;
        logic [3:0] trim;
        logic [2:0] drv;
    } cfg_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] data;
    } wr_t;

    function automatic logic drv_ok(input logic [2:0] code);
        return code <= DRV_MAX;
    endfunction

    // returns {bit9, bit8} of the band select field
    function automatic logic [1:0] band_sel(input band_e b);
        case (b)
            BAND_200M: return 2'b00;
            BAND_100M: return 2'b10;
            default:   return 2'b01;
        endcase
    endfunction

endpackage

// File: rtl/dllseq_fieldmap.sv
module dllseq_fieldmap
    import phy_dll_pkg::*;
(
    input  step_e             step,
    input  cfg_t              cfg,
    output wr_t               wr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam logic [DATA_W-1:0] M_EN   = ONE << B_DLL_EN;
    localparam logic [DATA_W-1:0] M_TAP  = (ONE << B_TAP_EN) | (DATA_W'(4'hF) << B_TAP_LO);
    localparam logic [DATA_W-1:0] M_BAND = DATA_W'(2'b11) << B_BAND_LO;
    localparam logic [DATA_W-1:0] M_TRIM = (DATA_W'(4'hF) << B_TRIM_LO) | (DATA_W'(3'h7) << B_DRV_LO);

    always_comb begin
        wr      = '0;
        rd_en   = 1'b0;
        rd_addr = A_STAT1;
        case (step)
            ST_DLL_OFF: begin
                wr.en = 1'b1; wr.addr = A_CTRL1; wr.mask = M_EN; wr.data = '0;
            end
            ST_TAP: begin
                wr.en = 1'b1; wr.addr = A_CTRL4; wr.mask = M_TAP;
                wr.data = (ONE << B_TAP_EN) | (DATA_W'(cfg.tap) << B_TAP_LO);
            end
            ST_BAND: begin
                wr.en = 1'b1; wr.addr = A_CTRL5; wr.mask = M_BAND;
                wr.data = DATA_W'(band_sel(cfg.band)) << B_BAND_LO;
            end
            ST_TRIM: begin
                wr.en = 1'b1; wr.addr = A_CTRL1; wr.mask = M_TRIM;
                wr.data = (DATA_W'(cfg.trim) << B_TRIM_LO) | (DATA_W'(cfg.drv) << B_DRV_LO);
            end
            ST_ENA: begin
                wr.en = 1'b1; wr.addr = A_CTRL1; wr.mask = M_EN; wr.data = M_EN;
            end
            ST_READ: rd_en = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dllseq_poll_timer.sv
module dllseq_poll_timer #(
    parameter int POLL_CYC    = 100000,
    parameter int TIMEOUT_CYC = 100000000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  logic gap_en,
    output logic gap_done,
    output logic expired
);
    localparam int GAP_W = $clog2(POLL_CYC + 1);
    localparam int TOT_W = $clog2(TIMEOUT_CYC + 1);

    logic [GAP_W-1:0] gap_cnt;
    logic [TOT_W-1:0] tot_cnt;

    always_ff @(posedge clk) begin
        if (rst || !gap_en) gap_cnt <= '0;
        else                gap_cnt <= gap_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || start)            tot_cnt <= '0;
        else if (active && !expired) tot_cnt <= tot_cnt + 1'b1;
    end

    assign gap_done = (gap_cnt == GAP_W'(POLL_CYC - 1));
    assign expired  = (tot_cnt >= TOT_W'(TIMEOUT_CYC));

    // R9: once the budget is used up it stays used up until restarted
    a_r9_expiry_holds: assert property (@(posedge clk) disable iff (rst)
        (expired && !start) |=> expired);

    // R7: the idle gap between reads never overruns the interval
    a_r7_gap_bounded: assert property (@(posedge clk) disable iff (rst)
        gap_en |-> (gap_cnt < GAP_W'(POLL_CYC)));
endmodule

// File: rtl/dllseq_ctrl.sv
module dllseq_ctrl
    import phy_dll_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  cfg_t  cfg_in,
    input  logic  rdy_bit,
    input  logic  gap_done,
    input  logic  expired,
    output step_e step,
    output cfg_t  cfg,
    output logic  dll_on,
    output logic  tmo_err,
    output logic  timer_start,
    output logic  poll_active,
    output logic  gap_en,
    output logic  clk_upd,
    output logic  busy,
    output logic  done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= ST_IDLE;
            cfg     <= '0;
            dll_on  <= 1'b0;
            tmo_err <= 1'b0;
        end else begin
            case (step)
                ST_IDLE: if (req && drv_ok(cfg_in.drv)) begin
                    cfg     <= cfg_in;
                    tmo_err <= 1'b0;
                    step    <= dll_on ? ST_DLL_OFF : ST_CLK;
                end
                ST_DLL_OFF: begin
                    dll_on <= 1'b0;
                    step   <= ST_CLK;
                end
                ST_CLK:   step <= (cfg.band == BAND_SLOW) ? ST_DONE : ST_TAP;
                ST_TAP:   step <= ST_BAND;
                ST_BAND:  step <= ST_TRIM;
                ST_TRIM:  step <= ST_ENA;
                ST_ENA:   step <= ST_READ;
                ST_READ:  step <= ST_CHECK;
                ST_CHECK: begin
                    if (rdy_bit) begin
                        dll_on <= 1'b1;
                        step   <= ST_DONE;
                    end else if (expired) begin
                        dll_on  <= 1'b1;
                        tmo_err <= 1'b1;
                        step    <= ST_DONE;
                    end else begin
                        step <= ST_WAIT;
                    end
                end
                ST_WAIT:  if (gap_done) step <= ST_READ;
                default:  step <= ST_IDLE;
            endcase
        end
    end

    assign timer_start = (step == ST_ENA);
    assign poll_active = (step == ST_READ) || (step == ST_CHECK) || (step == ST_WAIT);
    assign gap_en      = (step == ST_WAIT);
    assign clk_upd     = (step == ST_CLK);
    assign busy        = (step != ST_IDLE);
    assign done        = (step == ST_DONE);

    // R1: a running DLL is switched off before anything else
    a_r1_off_first: assert property (@(posedge clk) disable iff (rst)
        (step == ST_IDLE && req && drv_ok(cfg_in.drv) && dll_on) |=> (step == ST_DLL_OFF));

    // R2: slow band stops right after the clock update
    a_r2_slow_stops: assert property (@(posedge clk) disable iff (rst)
        (step == ST_CLK && cfg.band == BAND_SLOW) |=> (done && !dll_on));

    // R5: the enable write only ever follows the trim write
    a_r5_enable_after_trim: assert property (@(posedge clk) disable iff (rst)
        (step == ST_ENA) |-> ($past(step) == ST_TRIM));

    // R7: the DLL-on flag only rises at the end of polling
    a_r7_on_at_poll_end: assert property (@(posedge clk) disable iff (rst)
        $rose(dll_on) |-> ($past(step) == ST_CHECK && done));

    // R9: the error only rises on an expired budget
    a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_err) |-> $past(expired));

    // R10: a request while busy leaves the latched settings alone
    a_r10_cfg_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && step != ST_DONE) |=> $stable(cfg));
endmodule

// File: rtl/phy_dll_sequencer.sv
module phy_dll_sequencer
    import phy_dll_pkg::*;
#(
    parameter int POLL_CYC    = 100000,
    parameter int TIMEOUT_CYC = 100000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [1:0]        band,
    input  logic [3:0]        tap_sel,
    input  logic [3:0]        cp_trim,
    input  logic [2:0]        drv_code,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_mask,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              clk_upd,
    output logic              busy,
    output logic              done,
    output logic              tmo_err,
    output logic              dll_on
);
    cfg_t  cfg_in, cfg;
    step_e step;
    wr_t   wr;
    logic  rdy_bit, gap_done, expired, timer_start, poll_active, gap_en;

    assign cfg_in  = '{band: band_e'(band), tap: tap_sel, trim: cp_trim, drv: drv_code};
    assign rdy_bit = |(rd_data & (ONE << B_RDY));

    dllseq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .req(req), .cfg_in(cfg_in), .rdy_bit(rdy_bit),
        .gap_done(gap_done), .expired(expired), .step(step), .cfg(cfg),
        .dll_on(dll_on), .tmo_err(tmo_err), .timer_start(timer_start),
        .poll_active(poll_active), .gap_en(gap_en), .clk_upd(clk_upd),
        .busy(busy), .done(done)
    );

    dllseq_poll_timer #(.POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst(rst), .start(timer_start), .active(poll_active),
        .gap_en(gap_en), .gap_done(gap_done), .expired(expired)
    );

    dllseq_fieldmap u_map (
        .step(step), .cfg(cfg), .wr(wr), .rd_en(rd_en), .rd_addr(rd_addr)
    );

    assign wr_en   = wr.en;
    assign wr_addr = wr.addr;
    assign wr_mask = wr.mask;
    assign wr_data = wr.data;

    // R8: no write data outside its own mask
    a_r8_data_in_mask: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_data & ~wr_mask) == '0));

    // R10: the PHY is only touched while busy
    a_r10_write_when_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_en || rd_en) |-> busy);

    // R6: an invalid drive code does not start a sequence
    a_r6_bad_drive_ignored: assert property (@(posedge clk) disable iff (rst)
        (!busy && req && drv_code > DRV_MAX) |=> !busy);

    // R11: clock update is never issued outside a sequence
    a_r11_upd_in_seq: assert property (@(posedge clk) disable iff (rst)
        clk_upd |-> (busy && !wr_en));
endmodule

// File: tb/phy_dll_sequencer_test.sv
module phy_dll_sequencer_test;
    import phy_dll_pkg::*;

    localparam int POLL = 4;
    localparam int TMO  = 40;
    localparam logic [31:0] BG1 = 32'h5A5A_5A58;
    localparam logic [31:0] BG4 = 32'hC3C3_C3C3;
    localparam logic [31:0] BG5 = 32'h9696_9696;
    localparam logic [31:0] MK1 = 32'h0070_00F2;
    localparam logic [31:0] MK4 = 32'h0010_F000;
    localparam logic [31:0] MK5 = 32'h0000_0300;

    logic clk = 0, rst = 1, req = 0;
    logic [1:0] band = 0;
    logic [3:0] tap_sel = 0, cp_trim = 0;
    logic [2:0] drv_code = 0;
    logic wr_en, rd_en, clk_upd, busy, done, tmo_err, dll_on;
    logic [11:0] wr_addr, rd_addr;
    logic [31:0] wr_mask, wr_data, rd_data;

    int errors = 0, checks = 0, cycles = 0;

    always #5 clk = ~clk;

    phy_dll_sequencer #(.POLL_CYC(POLL), .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst(rst), .req(req), .band(band), .tap_sel(tap_sel),
        .cp_trim(cp_trim), .drv_code(drv_code), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_mask(wr_mask), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .clk_upd(clk_upd), .busy(busy), .done(done),
        .tmo_err(tmo_err), .dll_on(dll_on)
    );

    // behavioural PHY
    logic [31:0] ctrl1, ctrl4, ctrl5;
    int rcnt;
    int lat = 10;
    logic never = 0;
    logic rdy;
    assign rdy = ctrl1[1] && (rcnt >= lat) && !never;

    always @(posedge clk) begin
        if (rst) begin
            ctrl1 <= BG1; ctrl4 <= BG4; ctrl5 <= BG5; rcnt <= 0; rd_data <= '0;
        end else begin
            if (wr_en) begin
                if (wr_addr == 12'h100) ctrl1 <= (ctrl1 & ~wr_mask) | (wr_data & wr_mask);
                if (wr_addr == 12'h10C) ctrl4 <= (ctrl4 & ~wr_mask) | (wr_data & wr_mask);
                if (wr_addr == 12'h110) ctrl5 <= (ctrl5 & ~wr_mask) | (wr_data & wr_mask);
            end
            if (!ctrl1[1]) rcnt <= 0;
            else if (rcnt < lat) rcnt <= rcnt + 1;
            rd_data <= (rd_en && rd_addr == 12'h130) ? {31'b0, rdy} : 32'h0;
        end
    end

    // write log
    int wcount = 0, clk_cnt = 0, clk_at = -1;
    logic [11:0] waddr [0:15];
    logic [31:0] wmsk [0:15];
    logic [31:0] wdat [0:15];
    always @(posedge clk) begin
        if (!rst && wr_en && wcount < 16) begin
            waddr[wcount] <= wr_addr; wmsk[wcount] <= wr_mask; wdat[wcount] <= wr_data;
            wcount <= wcount + 1;
        end
        if (!rst && clk_upd) begin
            clk_cnt <= clk_cnt + 1;
            clk_at  <= wcount;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        wcount = 0; clk_cnt = 0; clk_at = -1;
    endtask

    task automatic pulse(input logic [1:0] b, input logic [3:0] t, input logic [3:0] tr, input logic [2:0] d);
        band = b; tap_sel = t; cp_trim = tr; drv_code = d; req = 1;
        @(negedge clk);
        req = 0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 400; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
    endtask

    function automatic logic [1:0] exp_band(input logic [1:0] b);
        case (b)
            2'd1: return 2'b00;
            2'd2: return 2'b10;
            default: return 2'b01;
        endcase
    endfunction

    bit prev_on = 0;

    task automatic run_one(input logic [1:0] b, input logic [3:0] t, input logic [3:0] tr, input logic [2:0] d);
        bit seen;
        int nexp, k;
        clear_log();
        pulse(b, t, tr, d);
        chk(busy == 1, "R10 busy after accept", 32'(busy), 1);
        wait_done(seen);
        chk(seen, "R7 done reached", 32'(seen), 1);
        @(negedge clk);
        nexp = (prev_on ? 1 : 0) + (b != 0 ? 4 : 0);
        chk(wcount == nexp, "R2/R5 write count", wcount, nexp);
        chk(clk_cnt == 1, "R11 one clock update", clk_cnt, 1);
        chk(clk_at == (prev_on ? 1 : 0), "R11/R1 clock update position", clk_at, prev_on ? 1 : 0);
        if (prev_on)
            chk(waddr[0] == 12'h100 && wmsk[0][1] && !wdat[0][1], "R1 DLL off write",
                {20'h0, waddr[0]}, 32'h100);
        k = prev_on ? 1 : 0;
        if (b != 0 && wcount == nexp) begin
            chk(waddr[k] == 12'h10C, "R3 tap write first", {20'h0, waddr[k]}, 32'h10C);
            chk(waddr[k+1] == 12'h110, "R4 band write second", {20'h0, waddr[k+1]}, 32'h110);
            chk(waddr[k+2] == 12'h100 && !wmsk[k+2][1], "R5 trim write alone", wmsk[k+2], MK1 & ~32'h2);
            chk(waddr[k+3] == 12'h100 && wmsk[k+3] == 32'h2 && wdat[k+3][1], "R5 enable write last",
                wmsk[k+3], 32'h2);
            chk(ctrl4[20] && ctrl4[15:12] == t, "R3 tap field", ctrl4, {11'h0, 1'b1, 4'h0, t, 12'h0});
            chk(ctrl5[9:8] == exp_band(b), "R4 band field", 32'(ctrl5[9:8]), 32'(exp_band(b)));
            chk(ctrl1[7:4] == tr && ctrl1[22:20] == d && ctrl1[1], "R5 trim/drive/enable", ctrl1,
                {9'h0, d, 12'h0, 4'h0, tr, 4'h2});
            chk(dll_on == 1, "R7 DLL on", 32'(dll_on), 1);
        end
        if (b == 0) chk(dll_on == 0 && ctrl1[1] == 0, "R2 DLL left off", 32'(dll_on), 0);
        chk((ctrl1 & ~MK1) == (BG1 & ~MK1), "R8 ctrl1 background", ctrl1 & ~MK1, BG1 & ~MK1);
        chk((ctrl4 & ~MK4) == (BG4 & ~MK4), "R8 ctrl4 background", ctrl4 & ~MK4, BG4 & ~MK4);
        chk((ctrl5 & ~MK5) == (BG5 & ~MK5), "R8 ctrl5 background", ctrl5 & ~MK5, BG5 & ~MK5);
        chk(tmo_err == 0, "R9 no error when ready", 32'(tmo_err), 0);
        chk(busy == 0, "R10 idle after done", 32'(busy), 0);
        prev_on = (b != 0);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin @(posedge clk); cycles++; end
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        bit seen;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !dll_on && !tmo_err && !wr_en && !rd_en, "reset state",
            {27'h0, busy, done, dll_on, tmo_err, wr_en}, 0);

        // sweep bands against field values, DLL on/off alternating naturally
        for (int i = 0; i < 20; i++)
            run_one(2'(i % 4), 4'(i * 7), 4'(15 - i), 3'(i % 5));

        // R6: invalid drive codes ignored
        for (int d = 5; d < 8; d++) begin
            clear_log();
            pulse(2'd3, 4'h3, 4'h3, 3'(d));
            repeat (4) @(negedge clk);
            chk(!busy && wcount == 0 && clk_cnt == 0, "R6 bad drive ignored", wcount, 0);
        end

        // R10: request while busy ignored
        run_one(2'd1, 4'h5, 4'h6, 3'd2);
        clear_log();
        pulse(2'd2, 4'h5, 4'h6, 3'd1);
        @(negedge clk);
        pulse(2'd3, 4'h9, 4'h1, 3'd0);
        wait_done(seen);
        @(negedge clk);
        chk(ctrl4[15:12] == 4'h5, "R10 busy request ignored (tap)", 32'(ctrl4[15:12]), 5);
        chk(ctrl5[9:8] == 2'b10, "R10 busy request ignored (band)", 32'(ctrl5[9:8]), 2);
        chk(clk_cnt == 1, "R10 single clock update", clk_cnt, 1);
        prev_on = 1;

        // R9: timeout path
        never = 1;
        clear_log();
        pulse(2'd3, 4'h2, 4'h2, 3'd4);
        wait_done(seen);
        chk(seen && tmo_err && dll_on, "R9 timeout flags", {30'h0, tmo_err, dll_on}, 3);
        @(negedge clk);
        chk(tmo_err == 1, "R9 error sticky", 32'(tmo_err), 1);
        never = 0;
        clear_log();
        pulse(2'd1, 4'h4, 4'h4, 3'd3);
        chk(tmo_err == 0, "R9 error cleared by request", 32'(tmo_err), 0);
        wait_done(seen);
        chk(seen && !tmo_err && dll_on, "R9 recovery run", {30'h0, tmo_err, dll_on}, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule